// File: doc/BRIEF.md
# Edge Timestamp Capture Unit

A register-mapped input capture peripheral. A free-running timestamp counter is copied into one of four capture slots each time a qualified edge arrives on a single input pin. Each slot has its own edge polarity. The pin is synchronised, edge-detected and passed through a programmable event prescaler. A slot sequencer then picks the destination slot, in either continuous or one-shot order.

Capture events and counter wrap-around set sticky per-event flags. Software clears these flags by writing one. An enabled event also sets a global flag, and that flag drives the interrupt output until software clears it. Software reaches everything through a simple 32-bit register bus. Reads are combinational from the address. A write takes effect at the clock edge where valid and write-enable are both high.

The register map is:

| Offset | Register |
|--------|----------|
| 0x00 | Counter |
| 0x08, 0x0C, 0x10, 0x14 | Capture slots 0 to 3 |
| 0x28 | Control |
| 0x2C | Enable and flag |
| 0x30 | Clear |

Top module: `edge_stamp_cap`

## Requirements
- R1: After reset, every register reads 0 and irq_o is low.
- R2: The counter at 0x00 increments by one each cycle while control bit 20 is 1, and holds while that bit is 0. A bus write to 0x00 loads the written value, and the write takes priority over counting.
- R3: When the running counter wraps from all ones to zero, it sets event flag 4, which reads at bit 21 of 0x2C.
- R4: The pin is synchronised with two flops. When an edge qualifies, the current slot stores a counter value two greater than the value readable at 0x00 in the cycle the pin changes.
- R5: Slot i waits for the edge that control bit 2·i selects: 1 selects a falling edge and 0 selects a rising edge. An edge of the other polarity does not advance the slot.
- R6: Control bits 13:9 hold a prescale value P. Every (P+1)-th edge that qualifies becomes a capture event, so P = 0 passes every edge. A rearm clears the prescale count.
- R7: When control bit 16 is 0 (continuous), the slot pointer steps 0, 1, and so on up to the stop index in control bits 18:17, then returns to slot 0.
- R8: When control bit 16 is 1 (one-shot), no further loads happen after the stop slot loads. They resume only after a control write with bit 19 = 1, which restarts the sequence at slot 0 with the prescale count cleared. Bit 19 always reads 0.
- R9: When control bit 8 is 0, edges are ignored. No slot loads, no flag sets and the prescaler does not count.
- R10: A load of slot i sets flag i, which reads at bit 17+i of 0x2C. Interrupt enables are written and read at bits 5:1 of 0x2C. Writing 1 to bit i+1 of 0x30 clears flag i. If a flag sets and clears in the same cycle, the set wins.
- R11: irq_o follows a global flag. The global flag sets when an event occurs whose enable bit is 1, and clears only when software writes 1 to bit 0 of 0x30.
- R12: Control bit 25 and every control bit not named above read as 0 and have no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| bus_valid_i | input | 1 | Bus access strobe |
| bus_we_i | input | 1 | Write enable, 1 = write |
| bus_addr_i | input | 6 | Byte address |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data, combinational from the address |
| cap_pin_i | input | 1 | Asynchronous capture input |
| irq_o | output | 1 | Interrupt, high while the global flag is set |

## Verification
The bench builds the block with its default parameters: a 32-bit counter, four slots and a 5-bit prescaler. Because the counter is writable, it can be preset to just below all ones, so a wrap and its overflow flag occur within a few cycles. The four slots let short pin sequences walk every stop index, polarity pattern and one-shot freeze. Random prescale values from 0 to 3 keep several prescaled captures inside a scenario of ten toggles.

// File: rtl/esc_pkg.sv
package esc_pkg;
  // byte offsets
  localparam int unsigned OFS_CNT  = 'h00;
  localparam int unsigned OFS_CAP  = 'h08;
  localparam int unsigned OFS_CTL  = 'h28;
  localparam int unsigned OFS_IEF  = 'h2C;
  localparam int unsigned OFS_CLR  = 'h30;
  // control bit positions
  localparam int unsigned B_LDEN    = 8;
  localparam int unsigned B_PS_LO   = 9;
  localparam int unsigned B_ONESHOT = 16;
  localparam int unsigned B_STOP_LO = 17;
  localparam int unsigned B_REARM   = 19;
  localparam int unsigned B_RUN     = 20;
  // enable / flag positions
  localparam int unsigned B_IEN_LO  = 1;
  localparam int unsigned B_FLG_LO  = 17;
endpackage

// File: rtl/esc_edge_qual.sv
module esc_edge_qual #(
  parameter int unsigned PS_W = 5
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            pin_i,
  input  logic            fall_sel_i,
  input  logic [PS_W-1:0] presc_i,
  input  logic            arm_i,
  input  logic            rearm_i,
  output logic            fire_o
);
  logic [1:0]      sync_q;
  logic            prev_q;
  logic [PS_W-1:0] pcnt_q;
  logic            cur, edge_hit, ps_done;

  assign cur      = sync_q[1];
  assign edge_hit = fall_sel_i ? (prev_q & ~cur) : (~prev_q & cur);
  assign ps_done  = (pcnt_q >= presc_i);
  assign fire_o   = arm_i & edge_hit & ps_done;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync_q <= '0;
      prev_q <= 1'b0;
    end else begin
      sync_q <= {sync_q[0], pin_i};
      prev_q <= sync_q[1];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pcnt_q <= '0;
    end else if (rearm_i) begin
      pcnt_q <= '0;
    end else if (arm_i && edge_hit) begin
      pcnt_q <= ps_done ? '0 : pcnt_q + 1'b1;
    end
  end

  // R6: count never advances while disarmed
  a_r6_idle_count: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!arm_i && !rearm_i) |=> $stable(pcnt_q));
endmodule

// File: rtl/esc_slot_seq.sv
module esc_slot_seq #(
  parameter int unsigned NUM_SLOTS = 4,
  localparam int unsigned SL_W = $clog2(NUM_SLOTS)
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 fire_i,
  input  logic                 rearm_i,
  input  logic                 oneshot_i,
  input  logic [SL_W-1:0]      stop_i,
  output logic [SL_W-1:0]      slot_o,
  output logic                 frozen_o,
  output logic [NUM_SLOTS-1:0] load_o
);
  logic [SL_W-1:0] slot_q;
  logic            frozen_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      slot_q   <= '0;
      frozen_q <= 1'b0;
    end else if (rearm_i) begin
      slot_q   <= '0;
      frozen_q <= 1'b0;
    end else if (fire_i) begin
      if (slot_q >= stop_i) begin
        slot_q   <= '0;
        frozen_q <= oneshot_i;
      end else begin
        slot_q <= slot_q + 1'b1;
      end
    end
  end

  for (genvar i = 0; i < NUM_SLOTS; i++) begin : g_load
    assign load_o[i] = fire_i && (slot_q == SL_W'(i));
  end

  assign slot_o   = slot_q;
  assign frozen_o = frozen_q;

  a_r8_frozen_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (frozen_q && !rearm_i) |=> frozen_q);
  a_r8_frozen_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frozen_q |-> !fire_i);
endmodule

// File: rtl/edge_stamp_cap.sv
module edge_stamp_cap
  import esc_pkg::*;
#(
  parameter int unsigned CNT_W     = 32,
  parameter int unsigned NUM_SLOTS = 4,
  parameter int unsigned PS_W      = 5,
  parameter int unsigned ADDR_W    = 6,
  parameter int unsigned DATA_W    = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              bus_valid_i,
  input  logic              bus_we_i,
  input  logic [ADDR_W-1:0] bus_addr_i,
  input  logic [DATA_W-1:0] bus_wdata_i,
  output logic [DATA_W-1:0] bus_rdata_o,
  input  logic              cap_pin_i,
  output logic              irq_o
);
  localparam int unsigned SL_W = $clog2(NUM_SLOTS);
  localparam int unsigned NEV  = NUM_SLOTS + 1;
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  function automatic logic [DATA_W-1:0] ctl_mask();
    logic [DATA_W-1:0] m;
    m = '0;
    for (int i = 0; i < NUM_SLOTS; i++) m[2*i] = 1'b1;
    m[B_LDEN] = 1'b1;
    for (int j = 0; j < PS_W; j++) m[B_PS_LO+j] = 1'b1;
    m[B_ONESHOT] = 1'b1;
    for (int j = 0; j < SL_W; j++) m[B_STOP_LO+j] = 1'b1;
    m[B_RUN] = 1'b1;
    return m;
  endfunction
  localparam logic [DATA_W-1:0] CTL_MASK = ctl_mask();

  logic [DATA_W-1:0]    ctl_q;
  logic [CNT_W-1:0]     cnt_q;
  logic [CNT_W-1:0]     cap_q [NUM_SLOTS];
  logic [NEV-1:0]       ien_q, flg_q, evt, clr_ev;
  logic                 glb_q, clr_glb;
  logic                 wr, cnt_wr, ctl_wr, ief_wr, clr_wr, rearm;
  logic                 cnt_run, ld_en, ovf_evt, arm, fire, frozen;
  logic [SL_W-1:0]      slot, stop;
  logic [PS_W-1:0]      presc;
  logic [NUM_SLOTS-1:0] pol_vec, load_vec;

  assign wr     = bus_valid_i & bus_we_i;
  assign cnt_wr = wr && (bus_addr_i == ADDR_W'(OFS_CNT));
  assign ctl_wr = wr && (bus_addr_i == ADDR_W'(OFS_CTL));
  assign ief_wr = wr && (bus_addr_i == ADDR_W'(OFS_IEF));
  assign clr_wr = wr && (bus_addr_i == ADDR_W'(OFS_CLR));
  assign rearm  = ctl_wr && bus_wdata_i[B_REARM];

  assign cnt_run = ctl_q[B_RUN];
  assign ld_en   = ctl_q[B_LDEN];
  assign presc   = ctl_q[B_PS_LO +: PS_W];
  assign stop    = ctl_q[B_STOP_LO +: SL_W];
  assign arm     = ld_en & ~frozen;

  for (genvar i = 0; i < NUM_SLOTS; i++) begin : g_pol
    assign pol_vec[i] = ctl_q[2*i];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     ctl_q <= '0;
    else if (ctl_wr) ctl_q <= bus_wdata_i & CTL_MASK;
  end

  // timestamp counter; bus write wins over counting
  assign ovf_evt = cnt_run && !cnt_wr && (cnt_q == CNT_MAX);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      cnt_q <= '0;
    else if (cnt_wr)  cnt_q <= bus_wdata_i[CNT_W-1:0];
    else if (cnt_run) cnt_q <= cnt_q + 1'b1;
  end

  esc_edge_qual #(.PS_W(PS_W)) i_qual (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .pin_i      (cap_pin_i),
    .fall_sel_i (pol_vec[slot]),
    .presc_i    (presc),
    .arm_i      (arm),
    .rearm_i    (rearm),
    .fire_o     (fire)
  );

  esc_slot_seq #(.NUM_SLOTS(NUM_SLOTS)) i_seq (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .fire_i    (fire),
    .rearm_i   (rearm),
    .oneshot_i (ctl_q[B_ONESHOT]),
    .stop_i    (stop),
    .slot_o    (slot),
    .frozen_o  (frozen),
    .load_o    (load_vec)
  );

  for (genvar i = 0; i < NUM_SLOTS; i++) begin : g_cap
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)          cap_q[i] <= '0;
      else if (load_vec[i]) cap_q[i] <= cnt_q;
    end
  end

  // flags: set wins over clear
  assign evt     = {ovf_evt, load_vec};
  assign clr_ev  = clr_wr ? bus_wdata_i[1 +: NEV] : '0;
  assign clr_glb = clr_wr & bus_wdata_i[0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ien_q <= '0;
      flg_q <= '0;
      glb_q <= 1'b0;
    end else begin
      if (ief_wr) ien_q <= bus_wdata_i[B_IEN_LO +: NEV];
      flg_q <= (flg_q & ~clr_ev) | evt;
      glb_q <= (glb_q & ~clr_glb) | (|(evt & ien_q));
    end
  end

  assign irq_o = glb_q;

  always_comb begin
    bus_rdata_o = '0;
    if (bus_addr_i == ADDR_W'(OFS_CNT)) bus_rdata_o = DATA_W'(cnt_q);
    if (bus_addr_i == ADDR_W'(OFS_CTL)) bus_rdata_o = ctl_q;
    if (bus_addr_i == ADDR_W'(OFS_IEF)) begin
      bus_rdata_o[B_IEN_LO +: NEV] = ien_q;
      bus_rdata_o[B_FLG_LO +: NEV] = flg_q;
    end
    for (int i = 0; i < NUM_SLOTS; i++) begin
      if (bus_addr_i == ADDR_W'(OFS_CAP + 4*i)) bus_rdata_o = DATA_W'(cap_q[i]);
    end
  end

  a_r2_cnt_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!cnt_run && !cnt_wr) |=> $stable(cnt_q));
  a_r3_ovf_flag: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_run && !cnt_wr && cnt_q == CNT_MAX) |=> flg_q[NUM_SLOTS]);
  a_r4_one_slot: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(load_vec));
  a_r9_no_load: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ld_en |-> (load_vec == '0));
  a_r10_flag_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flg_q[0] && !clr_ev[0]) |=> flg_q[0]);
  a_r11_irq_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_o && !clr_glb) |=> irq_o);
endmodule

// File: tb/test_edge_stamp_cap.sv
module test_edge_stamp_cap;
  localparam logic [5:0] A_CNT = 6'h00, A_CAP = 6'h08, A_CTL = 6'h28,
                         A_IEF = 6'h2C, A_CLR = 6'h30;

  logic        clk = 1'b0, rst_ni = 1'b0;
  logic        bus_valid = 1'b0, bus_we = 1'b0;
  logic [5:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0, bus_rdata;
  logic        pin = 1'b0, irq;

  int n_chk = 0, n_fail = 0;

  // model state
  logic [31:0] m_cap [4];
  logic [4:0]  m_flg, m_ien;
  logic        m_glb, m_frozen;
  logic [3:0]  m_pol;
  int          m_ps, m_pc, m_stop, m_slot;
  bit          m_one, m_ld;

  always #10 clk = ~clk;

  edge_stamp_cap i_edge_stamp_cap (
    .clk_i(clk), .rst_ni(rst_ni), .bus_valid_i(bus_valid), .bus_we_i(bus_we),
    .bus_addr_i(bus_addr), .bus_wdata_i(bus_wdata), .bus_rdata_o(bus_rdata),
    .cap_pin_i(pin), .irq_o(irq)
  );

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic tick(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(logic [5:0] a, logic [31:0] d);
    bus_addr = a; bus_wdata = d; bus_valid = 1'b1; bus_we = 1'b1;
    @(negedge clk);
    bus_valid = 1'b0; bus_we = 1'b0;
  endtask

  task automatic rd(logic [5:0] a, output logic [31:0] d);
    bus_addr = a;
    #1 d = bus_rdata;
  endtask

  function automatic logic [31:0] mk_ctl(logic [3:0] pol, int ps, bit one,
                                         int stop, bit ld, bit rearm);
    logic [31:0] c = 32'h0010_0000;  // run
    for (int i = 0; i < 4; i++) c[2*i] = pol[i];
    c[8] = ld; c[13:9] = 5'(ps); c[16] = one; c[18:17] = 2'(stop); c[19] = rearm;
    return c;
  endfunction

  // drive one pin transition and advance the model
  task automatic toggle();
    logic [31:0] c0;
    logic nl;
    nl = ~pin;
    rd(A_CNT, c0);
    pin = nl;
    if (m_ld && !m_frozen) begin
      if (m_pol[m_slot] ? (nl == 1'b0) : (nl == 1'b1)) begin
        if (m_pc >= m_ps) begin
          m_pc = 0;
          m_cap[m_slot] = c0 + 32'd2;
          m_flg[m_slot] = 1'b1;
          if (m_ien[m_slot]) m_glb = 1'b1;
          if (m_slot >= m_stop) begin m_slot = 0; m_frozen = m_one; end
          else m_slot++;
        end else m_pc++;
      end
    end
    tick(5);
  endtask

  task automatic scenario(string tag, logic [3:0] pol, int ps, bit one, int stop,
                          bit ld, logic [4:0] ien, bit rearm, int ntog);
    logic [31:0] v;
    wr(A_CLR, 32'h3F); m_flg = '0; m_glb = 1'b0;
    wr(A_IEF, {26'b0, ien, 1'b0}); m_ien = ien;
    wr(A_CTL, mk_ctl(pol, ps, one, stop, ld, rearm));
    m_pol = pol; m_ps = ps; m_one = one; m_stop = stop; m_ld = ld;
    if (rearm) begin m_slot = 0; m_pc = 0; m_frozen = 1'b0; end
    for (int k = 0; k < ntog; k++) toggle();
    for (int i = 0; i < 4; i++) begin
      rd(A_CAP + 6'(4*i), v);
      chk({tag, " capture slot"}, v, m_cap[i]);
    end
    rd(A_IEF, v);
    chk({tag, " R10 flags"}, v, ({27'b0, m_flg} << 17) | ({27'b0, m_ien} << 1));
    chk({tag, " R11 irq"}, {31'b0, irq}, {31'b0, m_glb});
  endtask

  initial begin
    logic [31:0] v, c;
    void'($urandom(32'd4242));
    for (int i = 0; i < 4; i++) m_cap[i] = '0;
    m_flg = '0; m_ien = '0; m_glb = 0; m_frozen = 0; m_slot = 0; m_pc = 0;
    tick(3);
    rst_ni = 1'b1;
    tick(2);

    // R1 reset state
    rd(A_CTL, v); chk("R1 ctl", v, 0);
    rd(A_CNT, v); chk("R1 cnt", v, 0);
    rd(A_IEF, v); chk("R1 ief", v, 0);
    rd(A_CAP, v); chk("R1 cap0", v, 0);
    chk("R1 irq", {31'b0, irq}, 0);

    // R2 counter hold, load, run
    rd(A_CNT, c); tick(5); rd(A_CNT, v); chk("R2 hold", v, c);
    wr(A_CNT, 32'd100); rd(A_CNT, v); chk("R2 load", v, 32'd100);
    wr(A_CTL, 32'h0010_0000);
    rd(A_CNT, c); tick(7); rd(A_CNT, v); chk("R2 run", v, c + 32'd7);

    // R3 overflow, R10 flag clear, R11 global stickiness
    wr(A_IEF, 32'h20);
    wr(A_CNT, 32'hFFFF_FFFD);
    tick(6);
    rd(A_IEF, v); chk("R3 ovf flag", v, 32'h0020_0020);
    chk("R11 irq set", {31'b0, irq}, 1);
    wr(A_CLR, 32'h20);
    rd(A_IEF, v); chk("R10 w1c", v, 32'h0000_0020);
    chk("R11 irq held", {31'b0, irq}, 1);
    wr(A_CLR, 32'h01);
    chk("R11 irq clr", {31'b0, irq}, 0);

    // directed capture scenarios
    scenario("R4 R5", 4'b0101, 0, 0, 3, 1, 5'h0F, 1, 8);
    scenario("R6",    4'b0000, 2, 0, 3, 1, 5'h01, 1, 12);
    scenario("R7",    4'b1010, 0, 0, 1, 1, 5'h02, 1, 10);
    scenario("R8 freeze",   4'b0011, 0, 1, 2, 1, 5'h1F, 1, 12);
    scenario("R8 norearm",  4'b0011, 0, 1, 2, 1, 5'h1F, 0, 4);
    scenario("R8 rearm",    4'b0011, 0, 1, 2, 1, 5'h1F, 1, 4);
    scenario("R9",    4'b0000, 0, 0, 3, 0, 5'h1F, 1, 6);

    // R12 ignored control bits, rearm reads 0
    wr(A_CTL, 32'hFFFF_FFFF);
    rd(A_CTL, v); chk("R12 ctl mask", v, 32'h0017_3F55);
    m_slot = 0; m_pc = 0; m_frozen = 1'b0;
    wr(A_CTL, 32'h0010_0000);
    rd(A_CTL, v); chk("R8 R12 rearm reads 0", v, 32'h0010_0000);

    // constrained random
    for (int it = 0; it < 8; it++) begin
      scenario("R5 R6 R7 R8 rand", 4'($urandom), int'($urandom % 4), bit'($urandom % 2),
               int'($urandom % 4), 1'b1, 5'($urandom), 1'b1, 10);
    end

    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog act=timeout exp=done");
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end
endmodule